// File: doc/BRIEF.md
# Trace Capture Qualifier

This block sits beside a monitored request bus and decides, cycle by cycle, whether the command currently on the bus should be written into a trace buffer. Each command carries an opcode, a source ID, a destination ID and an address. Three identical matchers examine every command: a capture filter, a start trigger and a stop trigger. Each matcher has an enable mask indexed by opcode, one-hot enable vectors for the source and destination IDs, and an address compare value with a per-bit care mask.

With the trigger feature off, the block records exactly the commands that the filter accepts. With it on, recording is confined to a window that a start-trigger hit opens and a stop-trigger hit closes. Inside the window, commands accepted by the filter and the trigger commands themselves are all recorded. The single output strobe tells the buffer writer to store the command of the previous cycle. The window state is also brought out.

Top module: `trc_capture_qual`

## Requirements
- R1: A cycle with `cmd_valid_i` low (idle) or with `cmd_rsp_i` high (response command) is never recorded and never moves the window, whatever the masks hold.
- R2: A matcher accepts a command only when all four sub-matches hold: bit `cmd_op_i` of its opcode enable is 1, bit `cmd_src_i` of its source enable is 1, bit `cmd_dst_i` of its destination enable is 1, and the address compares equal.
- R3: The address compare holds when `((cmd_addr_i ^ cmp) & msk) == 0`. A mask bit of 1 makes that address bit significant, and a mask bit of 0 makes it a don't-care.
- R4: With `trig_en_i` low, a live command is recorded if and only if the filter accepts it. The window stays closed, and trigger hits have no effect.
- R5: With `trig_en_i` high and the window closed, a start-trigger hit opens the window, and the start command itself is recorded.
- R6: With `trig_en_i` high, a command is recorded only when the window is open or the command is a start hit. It is then recorded if the filter, the start trigger or the stop trigger accepts it. A filter hit outside the window is not recorded.
- R7: A stop-trigger hit inside the window is recorded, and the window is closed from the next cycle on. A stop hit while the window is closed is not recorded and leaves the window closed.
- R8: A command that hits both start and stop while the window is closed is recorded, and the window is closed again after that cycle.
- R9: While `trace_en_i` is low, nothing is recorded and the window is forced closed. After `trace_en_i` is raised again, the window starts closed.
- R10: `rec_o` and `win_o` are registered. They reflect the command presented in the previous cycle, and both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trace_en_i | input | 1 | Trace enable; low blocks recording and closes the window |
| trig_en_i | input | 1 | Trigger window mode enable |
| cmd_valid_i | input | 1 | Command present (low = idle cycle) |
| cmd_rsp_i | input | 1 | Command is a response, never recorded |
| cmd_op_i | input | OP_W | Command opcode |
| cmd_src_i | input | ID_W | Source ID |
| cmd_dst_i | input | ID_W | Destination ID |
| cmd_addr_i | input | ADDR_W | Command address |
| flt_op_en_i | input | 2**OP_W | Filter opcode enable mask |
| flt_src_en_i | input | 2**ID_W | Filter one-hot source enable vector |
| flt_dst_en_i | input | 2**ID_W | Filter one-hot destination enable vector |
| flt_adr_cmp_i | input | ADDR_W | Filter address compare value |
| flt_adr_msk_i | input | ADDR_W | Filter address care mask |
| sta_op_en_i | input | 2**OP_W | Start trigger opcode enable mask |
| sta_src_en_i | input | 2**ID_W | Start trigger source enable vector |
| sta_dst_en_i | input | 2**ID_W | Start trigger destination enable vector |
| sta_adr_cmp_i | input | ADDR_W | Start trigger address compare value |
| sta_adr_msk_i | input | ADDR_W | Start trigger address care mask |
| stp_op_en_i | input | 2**OP_W | Stop trigger opcode enable mask |
| stp_src_en_i | input | 2**ID_W | Stop trigger source enable vector |
| stp_dst_en_i | input | 2**ID_W | Stop trigger destination enable vector |
| stp_adr_cmp_i | input | ADDR_W | Stop trigger address compare value |
| stp_adr_msk_i | input | ADDR_W | Stop trigger address care mask |
| rec_o | output | 1 | Record strobe for the previous cycle's command |
| win_o | output | 1 | Trigger window open |

## Verification
The bench builds the block with a 16-bit address and the default 4-bit opcode and 5-bit IDs. This keeps the masked-compare cases readable while leaving the full 16-entry opcode mask and 32-entry ID vectors in place. One destination bit is cleared in the filter, so a rejection that depends only on the destination can be observed. One opcode is shared by both triggers, so the same-cycle open-and-close case can be reached. The sequence walks the window through closed-stop, open, in-window filter and miss, response, close, reopen and trace-disable cases.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // Matcher slots, in the order they are instantiated.
  localparam int M_FLT   = 0;
  localparam int M_STA   = 1;
  localparam int M_STP   = 2;
  localparam int N_MATCH = 3;

  typedef logic [N_MATCH-1:0] hit_vec_t;
endpackage

// File: rtl/trc_cmd_match.sv
module trc_cmd_match #(
  parameter int OP_W   = 4,
  parameter int ID_W   = 5,
  parameter int ADDR_W = 36
) (
  input  logic [OP_W-1:0]       op_i,
  input  logic [ID_W-1:0]       src_i,
  input  logic [ID_W-1:0]       dst_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [(1<<OP_W)-1:0]  op_en_i,
  input  logic [(1<<ID_W)-1:0]  src_en_i,
  input  logic [(1<<ID_W)-1:0]  dst_en_i,
  input  logic [ADDR_W-1:0]     adr_cmp_i,
  input  logic [ADDR_W-1:0]     adr_msk_i,
  output logic                  hit_o
);
  logic op_ok, src_ok, dst_ok, adr_ok;

  always_comb begin
    op_ok  = op_en_i[op_i];
    src_ok = src_en_i[src_i];
    dst_ok = dst_en_i[dst_i];
    // Only the bits selected by the care mask take part in the compare.
    adr_ok = ((addr_i ^ adr_cmp_i) & adr_msk_i) == '0;
    hit_o  = op_ok & src_ok & dst_ok & adr_ok;
  end
endmodule

// File: rtl/trc_window.sv
module trc_window (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_en_i,
  input  logic trig_en_i,
  input  logic sta_hit_i,   // already qualified by a live command
  input  logic stp_hit_i,
  output logic gate_o,      // recording allowed for the current command
  output logic win_o
);
  logic win_q, win_n, win_upd;

  // Next-state logic.
  always_comb begin
    win_n = win_q;
    if (!trace_en_i || !trig_en_i)
      win_n = 1'b0;
    else if (stp_hit_i && (win_q || sta_hit_i))
      win_n = 1'b0;
    else if (sta_hit_i)
      win_n = 1'b1;
  end

  assign win_upd = !trace_en_i || !trig_en_i || sta_hit_i || stp_hit_i;
  assign gate_o  = trig_en_i && (win_q || sta_hit_i);
  assign win_o   = win_q;

  // State register with explicit enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win_q <= 1'b0;
    else if (win_upd)
      win_q <= win_n;
  end

  assert_start_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en_i && trig_en_i && sta_hit_i && !stp_hit_i) |=> win_q);

  assert_stop_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en_i && trig_en_i && stp_hit_i && win_q) |=> !win_q);

  assert_both_hit_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en_i && trig_en_i && sta_hit_i && stp_hit_i && !win_q) |=> !win_q);
endmodule

// File: rtl/trc_capture_qual.sv
module trc_capture_qual
  import trc_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int ID_W   = 5,
  parameter int ADDR_W = 36,
  localparam int NOP   = 1 << OP_W,
  localparam int NID   = 1 << ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en_i,
  input  logic              trig_en_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_rsp_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [ID_W-1:0]   cmd_src_i,
  input  logic [ID_W-1:0]   cmd_dst_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [NOP-1:0]    flt_op_en_i,
  input  logic [NID-1:0]    flt_src_en_i,
  input  logic [NID-1:0]    flt_dst_en_i,
  input  logic [ADDR_W-1:0] flt_adr_cmp_i,
  input  logic [ADDR_W-1:0] flt_adr_msk_i,
  input  logic [NOP-1:0]    sta_op_en_i,
  input  logic [NID-1:0]    sta_src_en_i,
  input  logic [NID-1:0]    sta_dst_en_i,
  input  logic [ADDR_W-1:0] sta_adr_cmp_i,
  input  logic [ADDR_W-1:0] sta_adr_msk_i,
  input  logic [NOP-1:0]    stp_op_en_i,
  input  logic [NID-1:0]    stp_src_en_i,
  input  logic [NID-1:0]    stp_dst_en_i,
  input  logic [ADDR_W-1:0] stp_adr_cmp_i,
  input  logic [ADDR_W-1:0] stp_adr_msk_i,
  output logic              rec_o,
  output logic              win_o
);
  logic [N_MATCH-1:0][NOP-1:0]    m_op_en;
  logic [N_MATCH-1:0][NID-1:0]    m_src_en;
  logic [N_MATCH-1:0][NID-1:0]    m_dst_en;
  logic [N_MATCH-1:0][ADDR_W-1:0] m_cmp;
  logic [N_MATCH-1:0][ADDR_W-1:0] m_msk;
  hit_vec_t hit_raw, hit;
  logic cmd_live, gate, rec_n, rec_q;

  assign m_op_en[M_FLT]  = flt_op_en_i;
  assign m_src_en[M_FLT] = flt_src_en_i;
  assign m_dst_en[M_FLT] = flt_dst_en_i;
  assign m_cmp[M_FLT]    = flt_adr_cmp_i;
  assign m_msk[M_FLT]    = flt_adr_msk_i;
  assign m_op_en[M_STA]  = sta_op_en_i;
  assign m_src_en[M_STA] = sta_src_en_i;
  assign m_dst_en[M_STA] = sta_dst_en_i;
  assign m_cmp[M_STA]    = sta_adr_cmp_i;
  assign m_msk[M_STA]    = sta_adr_msk_i;
  assign m_op_en[M_STP]  = stp_op_en_i;
  assign m_src_en[M_STP] = stp_src_en_i;
  assign m_dst_en[M_STP] = stp_dst_en_i;
  assign m_cmp[M_STP]    = stp_adr_cmp_i;
  assign m_msk[M_STP]    = stp_adr_msk_i;

  // Idle cycles and responses never count as commands.
  assign cmd_live = cmd_valid_i && !cmd_rsp_i && trace_en_i;

  for (genvar g = 0; g < N_MATCH; g++) begin : g_match
    trc_cmd_match #(
      .OP_W   (OP_W),
      .ID_W   (ID_W),
      .ADDR_W (ADDR_W)
    ) i_match (
      .op_i      (cmd_op_i),
      .src_i     (cmd_src_i),
      .dst_i     (cmd_dst_i),
      .addr_i    (cmd_addr_i),
      .op_en_i   (m_op_en[g]),
      .src_en_i  (m_src_en[g]),
      .dst_en_i  (m_dst_en[g]),
      .adr_cmp_i (m_cmp[g]),
      .adr_msk_i (m_msk[g]),
      .hit_o     (hit_raw[g])
    );
    assign hit[g] = hit_raw[g] && cmd_live;
  end

  trc_window i_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .trace_en_i (trace_en_i),
    .trig_en_i  (trig_en_i),
    .sta_hit_i  (hit[M_STA]),
    .stp_hit_i  (hit[M_STP]),
    .gate_o     (gate),
    .win_o      (win_o)
  );

  // Record decision (next state of the strobe).
  always_comb begin
    if (trig_en_i)
      rec_n = gate && (|hit);
    else
      rec_n = hit[M_FLT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rec_q <= 1'b0;
    else
      rec_q <= rec_n;
  end

  assign rec_o = rec_q;

  assert_idle_rsp_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid_i || cmd_rsp_i) |=> !rec_o);

  assert_filter_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en_i && !trig_en_i) |=> (rec_o == $past(hit[M_FLT])) && !win_o);

  assert_outside_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en_i && !win_o && !hit[M_STA]) |=> !rec_o);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en_i |=> (!rec_o && !win_o));
endmodule

// File: tb/test_trc_capture_qual.sv
module test_trc_capture_qual;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W = 4, ID_W = 5, ADDR_W = 16;
  localparam int NOP = 1 << OP_W, NID = 1 << ID_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trace_en = 1'b0, trig_en = 1'b0, valid = 1'b0, rsp = 1'b0;
  logic [OP_W-1:0] op = '0;
  logic [ID_W-1:0] src = '0, dst = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [NOP-1:0] f_op, s_op, p_op;
  logic [NID-1:0] f_src, f_dst, s_src, s_dst, p_src, p_dst;
  logic [ADDR_W-1:0] f_cmp, f_msk, s_cmp, s_msk, p_cmp, p_msk;
  logic rec, win;

  int checks = 0, errors = 0;

  typedef struct { bit rec; bit win; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trc_capture_qual #(.OP_W(OP_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) i_trc_capture_qual (
    .clk(clk), .rst_n(rst_n), .trace_en_i(trace_en), .trig_en_i(trig_en),
    .cmd_valid_i(valid), .cmd_rsp_i(rsp), .cmd_op_i(op), .cmd_src_i(src),
    .cmd_dst_i(dst), .cmd_addr_i(addr),
    .flt_op_en_i(f_op), .flt_src_en_i(f_src), .flt_dst_en_i(f_dst),
    .flt_adr_cmp_i(f_cmp), .flt_adr_msk_i(f_msk),
    .sta_op_en_i(s_op), .sta_src_en_i(s_src), .sta_dst_en_i(s_dst),
    .sta_adr_cmp_i(s_cmp), .sta_adr_msk_i(s_msk),
    .stp_op_en_i(p_op), .stp_src_en_i(p_src), .stp_dst_en_i(p_dst),
    .stp_adr_cmp_i(p_cmp), .stp_adr_msk_i(p_msk),
    .rec_o(rec), .win_o(win));

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Driver: present one command, push the result expected after the edge.
  task automatic step(string tag, bit te, bit tg, bit v, bit r,
                      int o, int s, int d, int a, bit e_rec, bit e_win);
    exp_t e;
    @(negedge clk);
    trace_en = te; trig_en = tg; valid = v; rsp = r;
    op = OP_W'(o); src = ID_W'(s); dst = ID_W'(d); addr = ADDR_W'(a);
    @(posedge clk);
    e.rec = e_rec; e.win = e_win; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares registered outputs at the falling edge after each command.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "rec_o", rec, e.rec);
        check(e.tag, "win_o", win, e.win);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Filter: opcodes 3 and 6, source 2 only, every destination but 9, address 0x12xx.
    f_op = '0; f_op[3] = 1'b1; f_op[6] = 1'b1;
    f_src = '0; f_src[2] = 1'b1;
    f_dst = '1; f_dst[9] = 1'b0;
    f_cmp = 16'h1200; f_msk = 16'hFF00;
    // Start: opcode 4 or 9. Stop: opcode 5 or 9. Any ID, address ignored.
    s_op = '0; s_op[4] = 1'b1; s_op[9] = 1'b1;
    p_op = '0; p_op[5] = 1'b1; p_op[9] = 1'b1;
    s_src = '1; s_dst = '1; p_src = '1; p_dst = '1;
    s_cmp = 16'hFFFF; s_msk = '0; p_cmp = 16'h0000; p_msk = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "reset rec_o", rec, 1'b0);
    check("R10", "reset win_o", win, 1'b0);
    rst_n = 1'b1;

    // Triggers off: filter alone decides (R4, R2, R3).
    step("R4",  1, 0, 1, 0, 3, 2, 7, 'h1234, 1, 0);
    step("R2",  1, 0, 1, 0, 3, 3, 7, 'h1234, 0, 0);  // source not enabled
    step("R2",  1, 0, 1, 0, 3, 2, 9, 'h1234, 0, 0);  // destination not enabled
    step("R2",  1, 0, 1, 0, 7, 2, 7, 'h1234, 0, 0);  // opcode not enabled
    step("R3",  1, 0, 1, 0, 3, 2, 7, 'h1334, 0, 0);  // cared bit differs
    step("R3",  1, 0, 1, 0, 6, 2, 7, 'h12FF, 1, 0);  // only don't-care bits differ
    step("R4",  1, 0, 1, 0, 4, 2, 7, 'h1234, 0, 0);  // start hit ignored
    step("R1",  1, 0, 0, 0, 3, 2, 7, 'h1234, 0, 0);  // idle
    step("R1",  1, 0, 1, 1, 3, 2, 7, 'h1234, 0, 0);  // response

    // Triggers on.
    step("R6",  1, 1, 1, 0, 3, 2, 7, 'h1234, 0, 0);  // filter hit outside window
    step("R7",  1, 1, 1, 0, 5, 2, 7, 'h0000, 0, 0);  // stop while closed
    step("R5",  1, 1, 1, 0, 4, 8, 1, 'h0042, 1, 1);  // start opens, recorded
    step("R6",  1, 1, 1, 0, 3, 2, 7, 'h1234, 1, 1);  // filter inside window
    step("R6",  1, 1, 1, 0, 7, 2, 7, 'h1234, 0, 1);  // miss inside window
    step("R1",  1, 1, 1, 1, 5, 2, 7, 'h1234, 0, 1);  // response stop ignored
    step("R7",  1, 1, 1, 0, 5, 6, 3, 'h0777, 1, 0);  // stop recorded, closes
    step("R7",  1, 1, 1, 0, 3, 2, 7, 'h1234, 0, 0);  // closed after stop
    step("R8",  1, 1, 1, 0, 9, 4, 4, 'h0001, 1, 0);  // start and stop together
    step("R8",  1, 1, 1, 0, 3, 2, 7, 'h1234, 0, 0);  // still closed
    step("R5",  1, 1, 1, 0, 4, 2, 7, 'h1234, 1, 1);  // reopen
    step("R9",  0, 1, 1, 0, 3, 2, 7, 'h1234, 0, 0);  // trace off closes
    step("R9",  1, 1, 1, 0, 3, 2, 7, 'h1234, 0, 0);  // restarts closed
    step("R9",  0, 0, 1, 0, 3, 2, 7, 'h1234, 0, 0);  // trace off, no trigger mode
    step("R1",  1, 1, 0, 0, 4, 2, 7, 'h1234, 0, 0);  // idle start does not open

    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule